// File: doc/BRIEF.md
# Approximate Fixed-Point Activation Unit

This unit evaluates one of three neural-network activations on a single fixed-point operand: a scaled exponential linear unit, a hyperbolic tangent, or a logistic sigmoid. An opcode picks the function. The exponential in the negative branch of the linear-unit function comes from a small stored table of points spaced half a unit apart, with linear interpolation between neighbouring points. The tangent uses a clipped rational expression. The sigmoid feeds half of its argument through that same approximate tangent and then shifts the result into the range zero to one.

A producer offers an operand and an opcode with a valid/ready handshake. The unit then runs a sequential restoring divider for the rational expression. Every opcode takes the same fixed number of cycles. The result is held on the output until the consumer takes it. A new operand is accepted only after that.

Top module: `act_unit`

## Requirements
- R1: Operands and results are signed 16-bit values with 10 fraction bits, so 1024 stands for 1.0. Opcode 0 selects the linear-unit function, 1 the tangent and 2 the sigmoid. Opcode 3 returns 0.
- R2: Linear-unit function, x > 0: the result is floor(1076·x / 1024), limited to 32767.
- R3: Linear-unit function, -8192 ≤ x ≤ 0: let t = -2·x, k = floor(t/1024) and w = t mod 1024. Table point P(k) = round(exp(-k/2)·1024) for k = 0..16. Then e = P(k) + floor((P(k+1) − P(k))·w / 1024) when k < 16, and e = P(16) when k = 16. The result is floor(1800·(e − 1024) / 1024).
- R4: Linear-unit function, x < -8192: e is P(16) with no extrapolation, so the result is -1800.
- R5: Tangent: an argument above 3072 gives 1024, and an argument below -3072 gives -1024.
- R6: Tangent, |a| ≤ 3072: let s = floor(a²/1024). The result is sign(a)·floor(|a|·(27648 + s) / (27648 + 9·s)).
- R7: Sigmoid: the result is floor((1024 + T) / 2). T is the R5/R6 tangent of the argument floor(x/2).
- R8: in_ready is high only while the unit is idle. An operand is taken on a rising edge where in_valid and in_ready are both high.
- R9: out_valid rises exactly QUOT_W+1 rising edges after the accepting edge, whatever the opcode. The default is 13.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold steady. in_valid and in_data have no effect while a result is pending.
- R11: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand can be taken |
| in_op | input | 2 | Function select |
| in_data | input | DATA_W | Operand, signed, 10 fraction bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Result, signed, 10 fraction bits |

## Verification
Two things can land in the same cycle here: the consumer taking a result, and the producer offering the next operand. The bench keeps in_valid high with a different operand while a result is in flight. It stalls out_ready for several cycles and then raises it while that operand is still being offered. The bench checks that the pending result is unchanged, and that in_ready stays low on the consuming edge. It also checks that the waiting operand is taken only one edge later, with full latency and its own correct value. Sweeps over dense and coarse operand ranges compare every opcode against an arithmetic model, with extra points at the table ends, the clip thresholds and saturation.

// File: rtl/act_pkg.sv
package act_pkg;
  localparam int FRAC = 10;
  localparam int ONE = 1 << FRAC;
  localparam int LAM_Q = 1076;
  localparam int LAMALPHA_Q = 1800;
  localparam int EXP_LAST = 16;

  typedef enum logic [1:0] {
    OP_SELU = 2'd0,
    OP_TANH = 2'd1,
    OP_SIG  = 2'd2,
    OP_NONE = 2'd3
  } actOp_e;

  typedef struct packed {
    logic load;
    logic divInit;
    logic divStep;
  } actCtrl_t;

  // exp(-k/2) in Q.10, k = 0..16
  function automatic int expPoint(input int k);
    case (k)
      0: return 1024;
      1: return 621;
      2: return 377;
      3: return 228;
      4: return 139;
      5: return 84;
      6: return 51;
      7: return 31;
      8: return 19;
      9: return 11;
      10: return 7;
      11: return 4;
      12: return 3;
      13: return 2;
      14: return 1;
      15: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/act_ctrl.sv
module act_ctrl
  import act_pkg::*;
#(
  parameter int QUOT_W = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     out_ready,
  output logic     in_ready,
  output logic     out_valid,
  output actCtrl_t ctrl
);
  localparam int CW = $clog2(QUOT_W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_DIV, S_DONE} state_e;

  state_e state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) state <= S_PREP;
        S_PREP: begin
          state   <= S_DIV;
          stepCnt <= CW'(QUOT_W - 1);
        end
        S_DIV: begin
          if (stepCnt == '0) state <= S_DONE;
          else stepCnt <= stepCnt - 1'b1;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready     = (state == S_IDLE);
  assign out_valid    = (state == S_DONE);
  assign ctrl.load    = (state == S_IDLE) && in_valid;
  assign ctrl.divInit = (state == S_PREP);
  assign ctrl.divStep = (state == S_DIV);
endmodule

// File: rtl/act_selu.sv
module act_selu
  import act_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y
);
  localparam logic signed [31:0] MAXV = 32'((1 << (DATA_W - 1)) - 1);

  logic signed [31:0] xs, posV, tIdx, tW, seg, e0, e1, eVal, negV;

  always_comb begin
    xs   = {{(32 - DATA_W){x[DATA_W-1]}}, x};
    posV = (xs * 32'(LAM_Q)) >>> FRAC;
    if (posV > MAXV) posV = MAXV;
    seg  = 32'sd0 - (xs <<< 1);
    tIdx = seg >>> FRAC;
    tW   = seg & 32'(ONE - 1);
    e0   = 32'(expPoint(int'(tIdx)));
    e1   = 32'(expPoint(int'(tIdx) + 1));
    if (tIdx >= 32'(EXP_LAST)) eVal = 32'(expPoint(EXP_LAST));
    else eVal = e0 + (((e1 - e0) * tW) >>> FRAC);
    negV = (32'(LAMALPHA_Q) * (eVal - 32'(ONE))) >>> FRAC;
    y    = (xs > 32'sd0) ? posV[DATA_W-1:0] : negV[DATA_W-1:0];
  end
endmodule

// File: rtl/act_dpath.sv
module act_dpath
  import act_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int QUOT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  actCtrl_t          ctrl,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data
);
  localparam int PW = 2 * DATA_W + 4;
  localparam int AW = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] THREE_Q = DATA_W'(3 * ONE);
  localparam logic signed [DATA_W-1:0] ONE_Q   = DATA_W'(ONE);

  logic signed [DATA_W-1:0] xReg;
  actOp_e opReg;
  logic [PW-1:0] remReg, dvsReg;
  logic [QUOT_W-1:0] qReg;
  logic negReg, hiReg, loReg;

  logic signed [DATA_W-1:0] tArg;
  logic [AW-1:0] tMag;
  logic [PW-1:0] sq, x2, numC, denC;

  always_comb begin
    tArg = (opReg == OP_SIG) ? (xReg >>> 1) : xReg;
    tMag = tArg[DATA_W-1] ? (~{1'b1, tArg} + 1'b1) : {1'b0, tArg};
    sq   = PW'(tMag) * PW'(tMag);
    x2   = sq >> FRAC;
    numC = PW'(tMag) * (PW'(27 * ONE) + x2);
    denC = PW'(27 * ONE) + PW'(9) * x2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xReg   <= '0;
      opReg  <= OP_NONE;
      remReg <= '0;
      dvsReg <= '0;
      qReg   <= '0;
      negReg <= 1'b0;
      hiReg  <= 1'b0;
      loReg  <= 1'b0;
    end else begin
      if (ctrl.load) begin
        xReg  <= in_data;
        opReg <= actOp_e'(in_op);
      end
      if (ctrl.divInit) begin
        remReg <= numC;
        dvsReg <= denC << (QUOT_W - 1);
        qReg   <= '0;
        negReg <= tArg[DATA_W-1];
        hiReg  <= tArg > THREE_Q;
        loReg  <= tArg < -THREE_Q;
      end
      if (ctrl.divStep) begin
        if (remReg >= dvsReg) begin
          remReg <= remReg - dvsReg;
          qReg   <= {qReg[QUOT_W-2:0], 1'b1};
        end else begin
          qReg   <= {qReg[QUOT_W-2:0], 1'b0};
        end
        dvsReg <= dvsReg >> 1;
      end
    end
  end

  logic signed [DATA_W-1:0] qExt, tanhVal, sigVal, seluVal;
  logic signed [DATA_W:0] sigSum;

  act_selu #(.DATA_W(DATA_W)) selu_i (.x(xReg), .y(seluVal));

  always_comb begin
    qExt = {{(DATA_W - QUOT_W){1'b0}}, qReg};
    if (hiReg) tanhVal = ONE_Q;
    else if (loReg) tanhVal = -ONE_Q;
    else if (negReg) tanhVal = -qExt;
    else tanhVal = qExt;
    sigSum = {tanhVal[DATA_W-1], tanhVal} + (DATA_W + 1)'(ONE);
    sigVal = sigSum[DATA_W:1];
    case (opReg)
      OP_SELU: out_data = seluVal;
      OP_TANH: out_data = tanhVal;
      OP_SIG:  out_data = sigVal;
      default: out_data = '0;
    endcase
  end
endmodule

// File: rtl/act_unit.sv
module act_unit
  import act_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int QUOT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  actCtrl_t ctrl;

  act_ctrl #(.QUOT_W(QUOT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .ctrl(ctrl)
  );

  act_dpath #(.DATA_W(DATA_W), .QUOT_W(QUOT_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_op(in_op),
    .in_data(in_data), .out_data(out_data)
  );
endmodule

// File: rtl/act_unit_chk.sv
module act_unit_chk #(
  parameter int DATA_W = 16,
  parameter int QUOT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(QUOT_W + 4) + 1;
  localparam logic signed [DATA_W-1:0] ONE_Q   = DATA_W'(1024);
  localparam logic signed [DATA_W-1:0] THREE_Q = DATA_W'(3072);

  logic [CNT_W-1:0] edgeCnt;
  logic pend;
  logic [1:0] opSeen;
  logic signed [DATA_W-1:0] xSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt <= '0;
      pend    <= 1'b0;
      opSeen  <= '0;
      xSeen   <= '0;
    end else if (in_valid && in_ready) begin
      edgeCnt <= '0;
      pend    <= 1'b1;
      opSeen  <= in_op;
      xSeen   <= in_data;
    end else if (pend && !out_valid) begin
      edgeCnt <= edgeCnt + 1'b1;
    end else if (out_valid) begin
      pend <= 1'b0;
    end
  end

  a_r8_not_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (pend && edgeCnt == CNT_W'(QUOT_W + 1)));

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r1_spare_opcode_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opSeen == 2'd3) |-> (out_data == '0));

  a_r5_tanh_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opSeen == 2'd1 && xSeen > THREE_Q) |-> ($signed(out_data) == ONE_Q));

  a_r7_sigmoid_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opSeen == 2'd2) |-> (!out_data[DATA_W-1] && $signed(out_data) <= ONE_Q));
endmodule

bind act_unit act_unit_chk #(.DATA_W(DATA_W), .QUOT_W(QUOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/act_unit_tb_top.sv
`timescale 1ns/1ps
module act_unit_tb_top;
  localparam int DW = 16;
  localparam int QW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  act_unit #(.DATA_W(DW), .QUOT_W(QW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic int tabPt(input int k);
    return $rtoi($exp(-0.5 * k) * 1024.0 + 0.5);
  endfunction

  function automatic int seluModel(input int x);
    int t, k, w, e, r;
    if (x > 0) begin
      r = (1076 * x) >>> 10;
      return (r > 32767) ? 32767 : r;
    end
    t = -2 * x;
    k = t / 1024;
    w = t % 1024;
    if (k >= 16) e = tabPt(16);
    else e = tabPt(k) + (((tabPt(k + 1) - tabPt(k)) * w) >>> 10);
    return (1800 * (e - 1024)) >>> 10;
  endfunction

  function automatic int tanhModel(input int a);
    int m, s, q;
    if (a > 3072) return 1024;
    if (a < -3072) return -1024;
    m = (a < 0) ? -a : a;
    s = (m * m) / 1024;
    q = (m * (27648 + s)) / (27648 + 9 * s);
    return (a < 0) ? -q : q;
  endfunction

  function automatic int opModel(input int op, input int x);
    case (op)
      0: return seluModel(x);
      1: return tanhModel(x);
      2: return (1024 + tanhModel(x >>> 1)) >>> 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int op, input int x);
    if (op == 0) return (x > 0) ? "R2" : ((x < -8192) ? "R4" : "R3");
    if (op == 1) return (x > 3072 || x < -3072) ? "R5" : "R6";
    if (op == 2) return "R7";
    return "R1";
  endfunction

  task automatic waitResult(output int lat);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(posedge clk);
      #1 lat++;
    end
  endtask

  task automatic runOp(input int op, input int x);
    int lat;
    int expv;
    expv = opModel(op, x);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_op    = 2'(op);
    in_data  = DW'(x);
    @(posedge clk);
    #1 in_valid = 1'b0;
    waitResult(lat);
    check(lat == QW + 1, "R9 latency", lat, QW + 1);
    check(int'($signed(out_data)) == expv, tagFor(op, x), int'($signed(out_data)), expv);
  endtask

  task automatic overlapTest();
    int lat;
    int expA;
    int expB;
    expA = opModel(1, -1500);
    expB = opModel(2, 2500);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_op     = 2'd1;
    in_data   = DW'(-1500);
    @(posedge clk);
    #1;
    in_op   = 2'd2;
    in_data = DW'(2500);
    // R10: operand B offered while A in flight must not disturb A
    waitResult(lat);
    check(lat == QW + 1, "R9 latency under stall", lat, QW + 1);
    check(int'($signed(out_data)) == expA, "R10 pending result", int'($signed(out_data)), expA);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      #1;
      check(out_valid == 1'b1, "R10 valid held", int'(out_valid), 1);
      check(int'($signed(out_data)) == expA, "R10 data held", int'($signed(out_data)), expA);
      check(in_ready == 1'b0, "R8 busy not ready", int'(in_ready), 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    // R8: consumed, but B not yet taken on that same edge
    check(in_ready == 1'b1, "R8 ready after consume", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8 result consumed", int'(out_valid), 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    waitResult(lat);
    check(lat == QW + 1, "R9 latency of waiting operand", lat, QW + 1);
    check(int'($signed(out_data)) == expB, "R7 waiting operand", int'($signed(out_data)), expB);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int corners[20];
    corners = '{-32768, 32767, 32000, 31000, -8192, -8193, -8191, -3072, -3073, 3072,
                3073, -6144, -6145, 6144, 6145, 0, 1, -1, -1331, -512};
    repeat (3) @(posedge clk);
    #1;
    check(in_ready == 1'b1, "R11 ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R11 no result in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R11 idle after reset", int'(out_valid), 0);

    for (int op = 0; op < 4; op++) begin
      foreach (corners[i]) runOp(op, corners[i]);
      for (int x = -32768; x <= 32767; x += 1021) runOp(op, x);
      for (int x = -9000; x <= 9000; x += 13) runOp(op, x);
    end
    overlapTest();
    runOp(0, -1331);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule